// File: doc/BRIEF.md
# Shared-Encoding Decode Router

This block sits between fetch and a group of instruction decode engines that all claim the same custom opcode. A pair of identifier registers, one for the vendor and one for the architecture, decides which engine owns that opcode. Software may write any value into either register. Only supported identifier pairs are kept, and a read always returns the pair that is in effect. Because a single register write changes what the shared opcode means, code can change meaning inside an inner loop, for example to alternate between two accelerators.

Each engine's enable is its opcode match ANDed with one select wire, so the enables are mutually exclusive. Engine 0 is the base decoder: it receives every instruction outside the shared opcode, and it receives the shared opcode when the base identifier is selected. A per-extension mask turns an extension's decoding off; its shared-opcode instructions then raise the illegal-instruction flag. After any identifier write, the block requests a fixed-length pipeline stall and withholds all enables until the stall ends. The block has no path into any engine's state, so a switch leaves that state unchanged.

Top module: `xdec_router`

## Requirements
- R1: After a synchronous active-low reset the vendor register reads 32'h0000_0A5C, the architecture register reads 32'h8000_0010 (engine 0), stall is 0, and no enable or illegal flag is raised.
- R2: A write of 32'h8000_0010 + k, with k below the engine count (4 by default), to the architecture register is accepted and reads back on the next cycle. csr_sel/csr_rsel = 1 addresses the architecture register and 0 addresses the vendor register.
- R3: A write of an unsupported value leaves the previous legal value in place, and reads return that value. Unsupported values are an architecture value outside the range or any vendor value other than 32'h0000_0A5C.
- R4: dec_en is one-hot or zero. A shared-opcode instruction (insn[6:0] = 7'h2B) goes only to the engine selected by the architecture register, provided that engine is enabled.
- R5: An instruction whose insn[6:0] is not 7'h2B raises dec_en[0] only, whatever the selection and mask.
- R6: If the selected engine k (k ≥ 1) has ext_mask[k-1] = 0, a shared-opcode instruction raises illegal and no enable.
- R7: Any identifier write, accepted or not, holds stall high for exactly STALL_CYC cycles (default 3), starting the cycle after the write. While stall is high, dec_en and illegal stay 0.
- R8: A second write made while a stall is in progress restarts the stall window at its full length.
- R9: When insn_valid is low, or when only identifier writes occur, no enable or illegal flag is raised. State kept by an engine is therefore never disturbed by a switch.
- R10: The first valid shared-opcode instruction after the stall from a write is routed according to the new identifier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | Identifier write strobe (write retires this cycle) |
| csr_sel | input | 1 | Write target: 0 vendor, 1 architecture |
| csr_wdata | input | 32 | Write value |
| csr_rsel | input | 1 | Read target: 0 vendor, 1 architecture |
| csr_rdata | output | 32 | Legal value in effect for the selected register |
| ext_mask | input | NUM_EXT | Per-extension decode on/off, bit k-1 for engine k |
| insn_valid | input | 1 | Fetch presents a valid instruction |
| insn | input | 32 | Instruction word |
| dec_en | output | NUM_EXT+1 | Engine enables, bit 0 base engine |
| illegal | output | 1 | Illegal-instruction flag |
| stall | output | 1 | Stall request to the pipeline |

## Verification
The enables and the illegal flag are combinational on the current instruction, mask and registered selection. The bench therefore sets inputs at a falling edge and samples them 1 ns later, within the same cycle. An identifier write is captured at the next rising edge, so read-back and the rise of stall are sampled at the falling edge after that write. The stall length is measured by counting consecutive falling edges on which stall is high, and the first instruction after a switch is applied at the first falling edge with stall low. Engine state is modelled by a bench counter that advances only on its engine's enable; it is compared before and after a series of switches.

// File: rtl/xdr_pkg.sv
// Package: shared types and default constants for the decode router.
// Assumes: one vendor value is supported; architecture values form a
// contiguous range starting at the base value, one per decode engine.
package xdr_pkg;

    // Which identifier register a CSR access addresses.
    typedef enum logic {
        ID_VENDOR = 1'b0,
        ID_ARCH   = 1'b1
    } id_sel_e;

    localparam logic [31:0] DEF_VENDOR    = 32'h0000_0A5C;
    localparam logic [31:0] DEF_ARCH_BASE = 32'h8000_0010;
    localparam logic [6:0]  DEF_SHARED_OPC = 7'h2B;

endpackage

// File: rtl/xdr_idreg.sv
// Module: write-any-read-legal identifier register pair.
// Keeps the vendor and architecture identifiers, accepts a write only if
// the resulting pair is supported, and derives the engine index from the
// architecture value. Assumes NUM_ENG >= 2.
module xdr_idreg
    import xdr_pkg::*;
#(
    parameter int          NUM_ENG   = 4,
    parameter logic [31:0] VENDOR    = DEF_VENDOR,
    parameter logic [31:0] ARCH_BASE = DEF_ARCH_BASE,
    localparam int         ENG_W     = $clog2(NUM_ENG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  id_sel_e          wr_sel,
    input  logic [31:0]      wr_data,
    input  id_sel_e          rd_sel,
    output logic [31:0]      rd_data,
    output logic [ENG_W-1:0] eng_sel
);

    logic [31:0] vendor_q;
    logic [31:0] arch_q;
    logic [31:0] wr_off;
    logic [31:0] cur_off;
    logic        arch_ok;
    logic        vend_ok;
    logic        unused_off_hi;

    // Legality of the value presented for each register.
    assign wr_off  = wr_data - ARCH_BASE;
    assign arch_ok = (wr_off < 32'(NUM_ENG));
    assign vend_ok = (wr_data == VENDOR);

    // Identifier storage: reset to the base pair, keep old value on illegal write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vendor_q <= VENDOR;
            arch_q   <= ARCH_BASE;
        end else if (wr_en) begin
            if (wr_sel == ID_VENDOR && vend_ok) vendor_q <= wr_data;
            if (wr_sel == ID_ARCH   && arch_ok) arch_q   <= wr_data;
        end
    end

    // Read port returns the legal value in effect.
    assign rd_data = (rd_sel == ID_ARCH) ? arch_q : vendor_q;

    // Engine index for the shared encoding.
    assign cur_off       = arch_q - ARCH_BASE;
    assign eng_sel       = cur_off[ENG_W-1:0];
    assign unused_off_hi = ^cur_off[31:ENG_W];

    // R3: a rejected architecture write leaves the register unchanged.
    a_r3_arch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == ID_ARCH && !arch_ok) |=> $stable(arch_q));

    // R3: a rejected vendor write leaves the register unchanged.
    a_r3_vendor_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == ID_VENDOR && !vend_ok) |=> $stable(vendor_q));

    // R2: an accepted architecture write is what is read back.
    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == ID_ARCH && arch_ok) |=> (arch_q == $past(wr_data)));

    // R3: the value in effect is always inside the supported range.
    a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_off < 32'(NUM_ENG)));

endmodule

// File: rtl/xdr_stall.sv
// Module: switch stall window.
// Loads STALL_CYC on every identifier write and counts down to zero;
// stall is requested while the count is non-zero. Assumes STALL_CYC >= 1.
module xdr_stall #(
    parameter int  STALL_CYC = 3,
    localparam int CNT_W     = $clog2(STALL_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    output logic stall
);

    logic [CNT_W-1:0] cnt_q;

    // Down-counter that restarts on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wr_en)
            cnt_q <= CNT_W'(STALL_CYC);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign stall = (cnt_q != '0);

    // R8: any write (including one during a stall) reloads the full window.
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt_q == CNT_W'(STALL_CYC)));

    // R7: without a write the window shrinks by one each cycle.
    a_r7_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/xdr_route.sv
// Module: mutually exclusive enable gating for the decode engines.
// Each engine enable is its opcode match ANDed with one select line.
// Engine 0 is the base decoder; engines 1..NUM_ENG-1 are extensions.
// Assumes eng_sel is always below NUM_ENG.
module xdr_route #(
    parameter int         NUM_ENG    = 4,
    parameter logic [6:0] SHARED_OPC = xdr_pkg::DEF_SHARED_OPC,
    localparam int        ENG_W      = $clog2(NUM_ENG)
) (
    input  logic               go,
    input  logic [6:0]         opcode,
    input  logic [ENG_W-1:0]   eng_sel,
    input  logic [NUM_ENG-2:0] ext_mask,
    output logic [NUM_ENG-1:0] dec_en,
    output logic               illegal
);

    logic               shared;
    logic [NUM_ENG-1:0] sel_hot;
    logic               ext_on;

    // Shared-region detection on the major opcode.
    assign shared = (opcode == SHARED_OPC);

    // One select wire per engine.
    for (genvar k = 0; k < NUM_ENG; k++) begin : g_sel
        assign sel_hot[k] = (eng_sel == ENG_W'(k));
    end

    // Base engine: everything outside the shared region, plus the shared
    // region when the base identifier is selected.
    assign dec_en[0] = go & (~shared | sel_hot[0]);

    // Extension engines: shared opcode AND select AND on/off mask.
    for (genvar k = 1; k < NUM_ENG; k++) begin : g_ext
        assign dec_en[k] = go & shared & sel_hot[k] & ext_mask[k-1];
    end

    // A selected extension that is masked off makes the encoding illegal.
    assign ext_on  = |(sel_hot[NUM_ENG-1:1] & ext_mask);
    assign illegal = go & shared & ~sel_hot[0] & ~ext_on;

endmodule

// File: rtl/xdec_router.sv
// Module: top of the shared-encoding decode router.
// Connects the identifier registers, the stall window and the enable
// gating. Decoding is withheld while a switch stall is in progress.
// Assumes fetch holds its instruction while stall is high.
module xdec_router
    import xdr_pkg::*;
#(
    parameter int          NUM_EXT    = 3,
    parameter int          STALL_CYC  = 3,
    parameter logic [31:0] VENDOR     = DEF_VENDOR,
    parameter logic [31:0] ARCH_BASE  = DEF_ARCH_BASE,
    parameter logic [6:0]  SHARED_OPC = DEF_SHARED_OPC,
    localparam int         NUM_ENG    = NUM_EXT + 1,
    localparam int         ENG_W      = $clog2(NUM_ENG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_we,
    input  logic               csr_sel,
    input  logic [31:0]        csr_wdata,
    input  logic               csr_rsel,
    output logic [31:0]        csr_rdata,
    input  logic [NUM_EXT-1:0] ext_mask,
    input  logic               insn_valid,
    input  logic [31:0]        insn,
    output logic [NUM_ENG-1:0] dec_en,
    output logic               illegal,
    output logic               stall
);

    logic [ENG_W-1:0] eng_sel;
    logic             go;
    logic             unused_insn_hi;

    // Only the major opcode takes part in routing.
    assign unused_insn_hi = ^insn[31:7];

    // Identifier register pair.
    xdr_idreg #(
        .NUM_ENG  (NUM_ENG),
        .VENDOR   (VENDOR),
        .ARCH_BASE(ARCH_BASE)
    ) u_idreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (csr_we),
        .wr_sel (id_sel_e'(csr_sel)),
        .wr_data(csr_wdata),
        .rd_sel (id_sel_e'(csr_rsel)),
        .rd_data(csr_rdata),
        .eng_sel(eng_sel)
    );

    // Stall window after each identifier write.
    xdr_stall #(
        .STALL_CYC(STALL_CYC)
    ) u_stall (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(csr_we),
        .stall(stall)
    );

    // Decode proceeds only for a valid instruction outside a stall.
    assign go = insn_valid & ~stall;

    // Enable gating.
    xdr_route #(
        .NUM_ENG   (NUM_ENG),
        .SHARED_OPC(SHARED_OPC)
    ) u_route (
        .go      (go),
        .opcode  (insn[6:0]),
        .eng_sel (eng_sel),
        .ext_mask(ext_mask),
        .dec_en  (dec_en),
        .illegal (illegal)
    );

    // R4: at most one engine is enabled.
    a_r4_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dec_en));

    // R6: an illegal instruction reaches no engine.
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (dec_en == '0));

    // R7: nothing is decoded while the stall is requested.
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (dec_en == '0 && !illegal));

    // R9: no valid instruction, no enable and no flag.
    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |-> (dec_en == '0 && !illegal));

    // R5: non-shared encodings always go to the base engine.
    a_r5_base: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && !stall && insn[6:0] != SHARED_OPC) |-> (dec_en == NUM_ENG'(1)));

endmodule

// File: tb/tb_xdec_router.sv
`timescale 1ns/1ps
module tb_xdec_router;

    localparam int          NUM_EXT = 3;
    localparam int          NUM_ENG = NUM_EXT + 1;
    localparam int          STALL   = 3;
    localparam logic [31:0] VEND    = 32'h0000_0A5C;
    localparam logic [31:0] ABASE   = 32'h8000_0010;
    localparam logic [6:0]  SHOPC   = 7'h2B;

    // Vector layout: [17:16] engine select, [15:13] mask, [12:6] opcode,
    // [5] valid, [4:1] expected dec_en, [0] expected illegal.
    localparam int NVEC = 12;
    localparam logic [17:0] VEC [NVEC] = '{
        {2'd0, 3'b111, 7'h2B, 1'b1, 4'b0001, 1'b0},
        {2'd0, 3'b000, 7'h33, 1'b1, 4'b0001, 1'b0},
        {2'd1, 3'b111, 7'h2B, 1'b1, 4'b0010, 1'b0},
        {2'd1, 3'b111, 7'h33, 1'b1, 4'b0001, 1'b0},
        {2'd1, 3'b110, 7'h2B, 1'b1, 4'b0000, 1'b1},
        {2'd2, 3'b111, 7'h2B, 1'b1, 4'b0100, 1'b0},
        {2'd2, 3'b101, 7'h2B, 1'b1, 4'b0000, 1'b1},
        {2'd3, 3'b100, 7'h2B, 1'b1, 4'b1000, 1'b0},
        {2'd3, 3'b011, 7'h2B, 1'b0, 4'b0000, 1'b0},
        {2'd3, 3'b011, 7'h2B, 1'b1, 4'b0000, 1'b1},
        {2'd0, 3'b000, 7'h2B, 1'b1, 4'b0001, 1'b0},
        {2'd2, 3'b000, 7'h13, 1'b1, 4'b0001, 1'b0}
    };

    logic               clk = 1'b0;
    logic               rst_n;
    logic               csr_we;
    logic               csr_sel;
    logic [31:0]        csr_wdata;
    logic               csr_rsel;
    logic [31:0]        csr_rdata;
    logic [NUM_EXT-1:0] ext_mask;
    logic               insn_valid;
    logic [31:0]        insn;
    logic [NUM_ENG-1:0] dec_en;
    logic               illegal;
    logic               stall;

    int nchk  = 0;
    int nfail = 0;
    int eng2_state = 0;

    always #2.5 clk = ~clk;

    xdec_router #(.NUM_EXT(NUM_EXT), .STALL_CYC(STALL)) dut (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rsel(csr_rsel), .csr_rdata(csr_rdata),
        .ext_mask(ext_mask), .insn_valid(insn_valid), .insn(insn),
        .dec_en(dec_en), .illegal(illegal), .stall(stall)
    );

    // Model of state inside engine 2: advances only when that engine is enabled.
    always @(posedge clk) if (dec_en[2]) eng2_state <= eng2_state + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Write one identifier register; called at a falling edge, returns at one.
    task automatic wr(input logic sel, input logic [31:0] val);
        csr_we = 1'b1; csr_sel = sel; csr_wdata = val;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    // Count cycles with stall high from the current falling edge onwards.
    task automatic wait_stall(output int n);
        n = 0;
        #1;
        while (stall && n < 100) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        #1_000_000;
        nfail++;
        $display("FAIL watchdog: run did not complete actual=%0d expected=0", 1);
        summary();
    end

    initial begin
        int n;
        int cur;
        int saved;
        rst_n = 1'b0; csr_we = 1'b0; csr_sel = 1'b0; csr_wdata = '0;
        csr_rsel = 1'b0; ext_mask = '0; insn_valid = 1'b0; insn = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        csr_rsel = 1'b0; #1;
        chk(csr_rdata == VEND, "R1 vendor reset", csr_rdata, VEND);
        csr_rsel = 1'b1; #1;
        chk(csr_rdata == ABASE, "R1 arch reset", csr_rdata, ABASE);
        chk(stall == 1'b0, "R1 stall reset", 32'(stall), 0);
        chk(dec_en == '0 && !illegal, "R1 outputs idle", 32'(dec_en), 0);

        // R2: legal architecture write reads back
        @(negedge clk);
        wr(1'b1, ABASE + 2);
        csr_rsel = 1'b1; #1;
        chk(csr_rdata == ABASE + 2, "R2 arch readback", csr_rdata, ABASE + 2);
        wait_stall(n);

        // R3: out-of-range architecture write is rejected
        @(negedge clk);
        wr(1'b1, ABASE + 4);
        csr_rsel = 1'b1; #1;
        chk(csr_rdata == ABASE + 2, "R3 arch kept", csr_rdata, ABASE + 2);
        wait_stall(n);
        @(negedge clk);
        wr(1'b1, 32'h0000_0003);
        csr_rsel = 1'b1; #1;
        chk(csr_rdata == ABASE + 2, "R3 arch kept low", csr_rdata, ABASE + 2);
        wait_stall(n);
        // R3: unsupported vendor write is rejected
        @(negedge clk);
        wr(1'b0, 32'hDEAD_BEEF);
        csr_rsel = 1'b0; #1;
        chk(csr_rdata == VEND, "R3 vendor kept", csr_rdata, VEND);

        // R7: stall length and quiet outputs during it (a rejected write still stalls)
        @(negedge clk);
        wait_stall(n);
        @(negedge clk);
        wr(1'b1, ABASE + 1);
        ext_mask = 3'b111; insn = {25'h0, SHOPC}; insn_valid = 1'b1; #1;
        chk(stall == 1'b1, "R7 stall rises", 32'(stall), 1);
        chk(dec_en == '0 && !illegal, "R7 no decode in stall", 32'(dec_en), 0);
        wait_stall(n);
        chk(n == STALL, "R7 stall length", n, STALL);
        // R10: first instruction after the stall uses the new owner
        chk(dec_en == 4'b0010, "R10 new owner", 32'(dec_en), 32'b0010);
        insn_valid = 1'b0;

        // R8: write during stall restarts the window
        @(negedge clk);
        wr(1'b1, ABASE + 2);
        @(negedge clk);
        wr(1'b1, ABASE + 2);
        wait_stall(n);
        chk(n == STALL, "R8 restarted length", n, STALL);

        // R9: engine state is untouched by switches with no valid instruction
        @(negedge clk);
        insn = {25'h0, SHOPC}; insn_valid = 1'b1;
        @(negedge clk);
        insn_valid = 1'b0;
        #1;
        saved = eng2_state;
        chk(saved == 1, "R9 engine seeded", saved, 1);
        wr(1'b1, ABASE + 3);
        #1; chk(dec_en == '0 && !illegal, "R9 no enable in switch", 32'(dec_en), 0);
        wait_stall(n);
        @(negedge clk);
        wr(1'b1, ABASE + 0);
        wait_stall(n);
        @(negedge clk);
        wr(1'b1, ABASE + 2);
        wait_stall(n);
        @(negedge clk);
        chk(eng2_state == saved, "R9 engine state kept", eng2_state, saved);
        cur = 2;

        // R4 R5 R6 R9: vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [17:0] v;
            v = VEC[i];
            if (int'(v[17:16]) != cur) begin
                wr(1'b1, ABASE + 32'(v[17:16]));
                wait_stall(n);
                @(negedge clk);
                cur = int'(v[17:16]);
            end
            ext_mask   = v[15:13];
            insn       = {25'h1ABCD ^ 25'(i), v[12:6]};
            insn_valid = v[5];
            #1;
            chk(dec_en == v[4:1], $sformatf("R4 R5 R6 vec %0d dec_en", i), 32'(dec_en), 32'(v[4:1]));
            chk(illegal == v[0], $sformatf("R6 R9 vec %0d illegal", i), 32'(illegal), 32'(v[0]));
            @(negedge clk);
            insn_valid = 1'b0;
        end

        summary();
    end

endmodule